// File: doc/BRIEF.md
# FIFO Flag Offset Configuration Loader

This block holds the four threshold offsets that drive the partial-level flags of a pair of FIFOs. There is an almost-empty offset and an almost-full offset for each FIFO. The almost-empty offset is counted from the empty boundary, and the almost-full offset is counted from the full boundary. The flag comparators elsewhere in the chip read the four offsets directly from the outputs of this block.

During master reset, two select inputs are sampled. They choose either one of three built-in offset values, applied to all four thresholds, or user programming. A mode input is sampled at the same time. It decides how user programming arrives:
- as whole words over a parallel data port, one word per strobe, or
- as a bit stream on a single serial input, one bit per enabled clock.

Until the fourth offset is in place, the block withholds the write enable of the FIFOs. A partial reset flushes the FIFOs. It leaves the offsets, the loading method and the loading progress untouched.

Top module: `flag_offset_loader`

## Requirements
- R1: Master reset is synchronous and active low. While it is low, select code `fsel` = 2'b01, 2'b10 and 2'b11 sets all four offsets to 8, 16 and 64 respectively, and `cfg_done` is high from the first clock after reset ends.
- R2: Select code `fsel` = 2'b00 during master reset clears `cfg_done`. While `cfg_done` is low, `wr_en` stays low even if `wr_req` is high.
- R3: Parallel loading applies when `ser_mode` was 0 during master reset. Each clock with `par_we` high stores `par_data` into the next offset, in this order: FIFO1 almost-empty, FIFO2 almost-empty, FIFO1 almost-full, FIFO2 almost-full. `cfg_done` rises on the clock that stores the fourth word.
- R4: Serial loading applies when `ser_mode` was 1 during master reset. Each clock with `ser_en` high shifts in `ser_bit`. The stream is 4×PTR_W bits, MSB first, in the same offset order as R3. `cfg_done` rises on the clock of the last bit.
- R5: The strobe of the method that was not selected (`ser_en` in parallel mode, `par_we` in serial mode) has no effect on the offsets or on `cfg_done`.
- R6: Once `cfg_done` is high, it stays high and the offsets stay constant until the next master reset. Further strobes of either kind are ignored.
- R7: Partial reset (`prst_n` low) changes neither the offsets, nor `cfg_done`, nor the selected method, nor the loading progress.
- R8: `wr_en` is high exactly when `wr_req` is high, `cfg_done` is high and `prst_n` is high.
- R9: In serial mode, a clock with `ser_en` low shifts nothing, whatever value `ser_bit` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, active low; only gates writes |
| fsel | input | 2 | Offset select, sampled during master reset |
| ser_mode | input | 1 | 1 selects serial loading, sampled during master reset |
| par_we | input | 1 | Parallel offset write strobe |
| par_data | input | PTR_W | Parallel offset word |
| ser_en | input | 1 | Serial shift enable |
| ser_bit | input | 1 | Serial data bit |
| wr_req | input | 1 | FIFO write request |
| wr_en | output | 1 | Gated FIFO write enable |
| cfg_done | output | 1 | All four offsets are loaded |
| ae1_off | output | PTR_W | FIFO1 almost-empty offset |
| ae2_off | output | PTR_W | FIFO2 almost-empty offset |
| af1_off | output | PTR_W | FIFO1 almost-full offset |
| af2_off | output | PTR_W | FIFO2 almost-full offset |

## Verification
The bench builds the block with PTR_W = 7. This is the narrowest width that still holds the 64 default, so the default lands in the top bit of the offset field. The serial stream is then 28 bits, which makes it short enough to run many full serial loads with random gaps and still reach both all-ones and all-zero words. Each trial draws a random select code and a random method. It scatters idle cycles, strobes of the unselected method and partial-reset pulses through the load, and compares the offsets with values that the bench itself computes.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic [1:0]       fsel,
  input  logic             ser_mode,
  input  logic             par_we,
  input  logic [PTR_W-1:0] par_data,
  input  logic             ser_en,
  input  logic             ser_bit,
  input  logic             wr_req,
  output logic             wr_en,
  output logic             cfg_done,
  output logic [PTR_W-1:0] ae1_off,
  output logic [PTR_W-1:0] ae2_off,
  output logic [PTR_W-1:0] af1_off,
  output logic [PTR_W-1:0] af2_off
);
  localparam int TOT = 4 * PTR_W;
  localparam int CW  = $clog2(TOT);

  logic [TOT-1:0] offs;
  logic [CW-1:0]  cnt;
  logic           ser_q;
  logic           ld, last;

  function automatic logic [PTR_W-1:0] dflt(input logic [1:0] s);
    case (s)
      2'b01:   return PTR_W'(8);
      2'b10:   return PTR_W'(16);
      2'b11:   return PTR_W'(64);
      default: return '0;
    endcase
  endfunction

  assign ld   = !cfg_done && (ser_q ? ser_en : par_we);
  assign last = ser_q ? (cnt == CW'(TOT - 1)) : (cnt == CW'(3));

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ser_q    <= ser_mode;
      cfg_done <= |fsel;
      cnt      <= '0;
      offs     <= {4{dflt(fsel)}};
    end else if (ld) begin
      cnt <= cnt + CW'(1);
      if (last) cfg_done <= 1'b1;
      if (ser_q) offs <= {offs[TOT-2:0], ser_bit};
      else       offs[(3 - int'(cnt[1:0])) * PTR_W +: PTR_W] <= par_data;
    end
  end

  assign ae1_off = offs[TOT-1 -: PTR_W];
  assign ae2_off = offs[3*PTR_W-1 -: PTR_W];
  assign af1_off = offs[2*PTR_W-1 -: PTR_W];
  assign af2_off = offs[PTR_W-1:0];
  assign wr_en   = wr_req & cfg_done & prst_n;

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    cfg_done |=> cfg_done);

  // R6
  offs_frozen_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    cfg_done |=> $stable(offs));

  // R2
  wr_block_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    wr_en |-> (cfg_done && prst_n));

  // R5
  par_idle_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!ser_q && !par_we) |=> $stable(offs) && $stable(cnt));

  // R9
  ser_idle_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_q && !ser_en) |=> $stable(offs) && $stable(cnt));

  // R7
  mode_kept_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> $stable(ser_q));
endmodule

// File: tb/sim_flag_offset_loader.sv
`timescale 1ns/1ps
module sim_flag_offset_loader;
  localparam int W   = 7;
  localparam int TOT = 4 * W;

  logic clk = 0, mrst_n = 0, prst_n = 1, ser_mode = 0, par_we = 0, ser_en = 0, ser_bit = 0, wr_req = 0;
  logic [1:0] fsel = 0;
  logic [W-1:0] par_data = 0;
  logic wr_en, cfg_done;
  logic [W-1:0] ae1_off, ae2_off, af1_off, af2_off;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  flag_offset_loader #(.PTR_W(W)) u0 (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fsel(fsel), .ser_mode(ser_mode),
    .par_we(par_we), .par_data(par_data), .ser_en(ser_en), .ser_bit(ser_bit),
    .wr_req(wr_req), .wr_en(wr_en), .cfg_done(cfg_done),
    .ae1_off(ae1_off), .ae2_off(ae2_off), .af1_off(af1_off), .af2_off(af2_off));

  function automatic logic [W-1:0] exp_dflt(input logic [1:0] s);
    return (s == 2'b01) ? W'(8) : (s == 2'b10) ? W'(16) : (s == 2'b11) ? W'(64) : W'(0);
  endfunction

  function automatic logic [TOT-1:0] got();
    return {ae1_off, ae2_off, af1_off, af2_off};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic noise();
    par_data = W'($urandom); ser_bit = 1'($urandom);
    prst_n = ($urandom % 4) != 0; wr_req = 1'($urandom);
  endtask

  task automatic mreset(input logic [1:0] s, input logic m);
    mrst_n = 0; fsel = s; ser_mode = m; par_we = 0; ser_en = 0; prst_n = 1;
    tick(); tick();
    mrst_n = 1; fsel = 2'($urandom); ser_mode = 1'($urandom);
  endtask

  task automatic check_idle_after(input logic [TOT-1:0] exp);
    for (int i = 0; i < 4; i++) begin
      noise(); par_we = 1'($urandom); ser_en = 1'($urandom);
      tick();
      chk("R6 offsets frozen", 32'(got()), 32'(exp));
      chk("R6 done held", 32'(cfg_done), 32'd1);
      chk("R8 wr_en gating", 32'(wr_en), 32'(wr_req & prst_n));
    end
    par_we = 0; ser_en = 0;
    prst_n = 0; wr_req = 1; tick();
    chk("R7 offsets kept in partial reset", 32'(got()), 32'(exp));
    chk("R7 writes blocked in partial reset", 32'(wr_en), 32'd0);
    prst_n = 1; tick();
    chk("R8 write passes", 32'(wr_en), 32'd1);
    wr_req = 0;
  endtask

  task automatic load_par(input logic [TOT-1:0] v);
    for (int k = 0; k < 4; k++) begin
      int gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin
        noise(); par_we = 0; ser_en = 1'($urandom); tick();
        chk("R5 not done during gap", 32'(cfg_done), 32'd0);
      end
      noise(); ser_en = 1'($urandom); par_we = 1; par_data = v[TOT-1-k*W -: W];
      tick();
      par_we = 0;
      chk("R3 done timing", 32'(cfg_done), 32'(k == 3));
      chk("R2 write blocked", 32'(wr_en), 32'(k == 3 ? (wr_req & prst_n) : 1'b0));
    end
    chk("R3 parallel order", 32'(got()), 32'(v));
  endtask

  task automatic load_ser(input logic [TOT-1:0] v);
    for (int i = TOT - 1; i >= 0; i--) begin
      int gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin
        noise(); ser_en = 0; par_we = 1'($urandom); tick();
      end
      noise(); par_we = 1'($urandom); ser_en = 1; ser_bit = v[i];
      tick();
      ser_en = 0; par_we = 0;
      if (i == 1) chk("R4 not done before last bit", 32'(cfg_done), 32'd0);
    end
    chk("R4 done after last bit", 32'(cfg_done), 32'd1);
    chk("R4 R9 serial stream", 32'(got()), 32'(v));
  endtask

  task automatic trial(input logic [1:0] s, input logic m, input logic [TOT-1:0] v);
    mreset(s, m);
    chk("R1 R2 done after reset", 32'(cfg_done), 32'(s != 0));
    if (s != 0) begin
      chk("R1 default offsets", 32'(got()), 32'({4{exp_dflt(s)}}));
      check_idle_after({4{exp_dflt(s)}});
    end else begin
      wr_req = 1; tick();
      chk("R2 writes blocked before load", 32'(wr_en), 32'd0);
      if (m) load_ser(v); else load_par(v);
      check_idle_after(v);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    tick();
    mreset(2'b00, 1'b0);
    chk("R2 reset state done low", 32'(cfg_done), 32'd0);
    chk("R2 reset state wr_en low", 32'(wr_en), 32'd0);
    trial(2'b01, 0, '0);
    trial(2'b10, 1, '0);
    trial(2'b11, 0, '0);
    trial(2'b00, 0, {W'(1), W'(2), W'(3), W'(4)});
    trial(2'b00, 1, {TOT{1'b1}});
    trial(2'b00, 1, {W'(0), {W{1'b1}}, W'(0), W'(64)});
    trial(2'b00, 0, {{W{1'b1}}, W'(0), {W{1'b1}}, W'(0)});
    for (int t = 0; t < 40; t++)
      trial(2'($urandom), 1'($urandom), TOT'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule